// File: doc/BRIEF.md
# Programmable Frame and Slot Serial Transmitter

This block is the transmit side of a master serial audio port. On every pulse of a bit-clock enable it produces one bit of a frame: the frame-sync level, the serial data bit and the data output-enable. One set of runtime settings covers two-channel I2S, left-justified, short-pulse PCM/DSP and multi-slot TDM framing. These settings are the frame length, the width, polarity and early start of frame sync, the slot count, width and enable mask, the data width, the data offset inside a slot, the bit order and the fill used for idle bits.

Samples arrive as right-aligned 32-bit words on a valid/ready port, one word for each active slot. The word is taken at the first bit of its slot. A controller sets the configuration while `cfg_enable` is low, raises `cfg_enable`, and supplies a bit-clock enable from its own divider. A mute request takes effect at frame boundaries only. Underruns are recorded in a sticky flag, and slot alignment is kept when one occurs.

A three-state machine controls the sequencing. `ST_IDLE` holds the counters at position 0 with all outputs quiet. `ST_SLOT` means the current bit position lies in an active slot. `ST_QUIET` means it lies in a masked slot or in the tail after the last declared slot. The transitions are:
- start: `ST_IDLE` to the class of position 0, on the first clock with `cfg_enable` high.
- step: `ST_SLOT` or `ST_QUIET` to the class of the next position, on each bit-clock enable.
- stop: any state to `ST_IDLE`, on the clock after `cfg_enable` falls.

Top module: `tdm_frame_tx`

## Requirements
- R1: Out of reset, and on the clock after `cfg_enable` is seen low, the outputs are quiet: `sd_oe`=0, `sd`=0, `in_ready`=0, and `fs` sits at its inactive level (the inverse of `cfg_fs_active_high`).
- R2: When running, each `bclk_en` pulse emits one bit, and a frame lasts `cfg_frame_len_m1`+1 pulses. `fs`, `sd` and `sd_oe` hold their values on clocks without `bclk_en`.
- R3: Frame sync is active for bit positions 0 to `cfg_fs_len_m1`. When `cfg_fs_early`=1, the active window starts one bit earlier: it covers the last bit of the previous frame and positions 0 to `cfg_fs_len_m1`-1. The active level is high when `cfg_fs_active_high`=1 and low when it is 0.
- R4: Slot width is encoded as 0 = data width, 1 = 16 bits, 2 = 32 bits. Slot i occupies positions i·width up to (i+1)·width-1. Slots 0 to `cfg_slot_count_m1` are declared. A declared slot i is active when `cfg_slot_mask[i]`=1.
- R5: In an active slot, `sd_oe`=1. Data bits occupy slot bits `cfg_first_bit_off` to `cfg_first_bit_off`+`cfg_data_bits_m1`. They are sent from word bit `cfg_data_bits_m1` down to bit 0, or from bit 0 upward when `cfg_lsb_first`=1. Every other bit of the slot is 0, and word bits above the data width are never sent.
- R6: In a masked slot and in the tail after the last declared slot, `sd`=0. `sd_oe` is 0 when `cfg_idle_hiz`=1 and 1 otherwise.
- R7: `in_ready` is high exactly in the clock whose `bclk_en` emits bit 0 of an active slot. No word is taken for a masked slot or for the tail.
- R8: If `in_valid` is low when a word is due, the slot is sent as all zeros, alignment is unchanged, and `underrun` goes high and stays high until reset.
- R9: `cfg_mute_req` is sampled only at the emission of the last bit of a frame, and at start. The sampled value governs the whole of the following frame.
- R10: In a muted frame, words are still taken as in R7. Active slots carry zeros, or, when `cfg_mute_repeat`=1, the last word taken during an unmuted frame (0 if none was taken since reset).
- R11: After a stop, the next start begins again at frame position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_en | input | 1 | One-cycle strobe per bit period |
| cfg_enable | input | 1 | Run the frame generator |
| cfg_frame_len_m1 | input | 8 | Bits per frame minus one |
| cfg_fs_len_m1 | input | 7 | Frame-sync active bits minus one |
| cfg_fs_active_high | input | 1 | Frame-sync active level is high |
| cfg_fs_early | input | 1 | Start frame sync one bit before slot 0 |
| cfg_slot_count_m1 | input | 4 | Declared slots minus one |
| cfg_slot_mask | input | 16 | Per-slot enable |
| cfg_slot_size | input | 2 | Slot width code (R4) |
| cfg_data_bits_m1 | input | 5 | Data bits per word minus one |
| cfg_first_bit_off | input | 5 | Data start within slot |
| cfg_lsb_first | input | 1 | Send bit 0 first |
| cfg_idle_hiz | input | 1 | Release the line on idle bits |
| cfg_mute_req | input | 1 | Request muted frames |
| cfg_mute_repeat | input | 1 | Muted slots repeat last word |
| in_data | input | 32 | Right-aligned sample word |
| in_valid | input | 1 | Sample word available |
| in_ready | output | 1 | Sample word taken this clock |
| fs | output | 1 | Frame sync |
| sd | output | 1 | Serial data |
| sd_oe | output | 1 | Serial data output-enable |
| underrun | output | 1 | Sticky missing-word flag |

## Verification
A position counter that is off by one shows up on `fs` within one frame, because the sync edge lands on the wrong bit. A wrong state class shows on `sd_oe` in hi-z mode, and as a misplaced `in_ready` pulse, at the first slot boundary after the fault. Faults in word holding or mute selection show as wrong data bits within the affected slot. These are caught because every emitted bit is compared against an arithmetic model of frame position, slot index and bit index. The run sweeps mask, bit order, fill mode, early sync and polarity over a small frame, then covers I2S, wide TDM, a 256-bit frame, mute changes in mid-frame and underrun.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SLOT  = 2'd1,
        ST_QUIET = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        SZ_DATA = 2'd0,
        SZ_16   = 2'd1,
        SZ_32   = 2'd2,
        SZ_RSVD = 2'd3
    } slot_size_e;
endpackage

// File: rtl/tdm_pos_counter.sv
module tdm_pos_counter #(
    parameter int FRAME_W   = 8,
    parameter int SLOT_W    = 5,
    parameter int BIT_W     = 6,
    parameter int MAX_SLOTS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               step,
    input  logic [FRAME_W-1:0] last_pos,
    input  logic [BIT_W-1:0]   slot_bits,
    output logic [FRAME_W-1:0] pos,
    output logic [SLOT_W-1:0]  slot,
    output logic [BIT_W-1:0]   bslot,
    output logic [SLOT_W-1:0]  slot_nxt,
    output logic               frame_end
);
    logic               slot_end;
    logic [FRAME_W-1:0] pos_nxt;
    logic [BIT_W-1:0]   bslot_nxt;

    always_comb begin
        frame_end = (pos >= last_pos);
        slot_end  = (({1'b0, bslot} + (BIT_W+1)'(1)) >= {1'b0, slot_bits});
        if (frame_end) begin
            pos_nxt   = '0;
            bslot_nxt = '0;
            slot_nxt  = '0;
        end else begin
            pos_nxt = pos + FRAME_W'(1);
            if (slot_end) begin
                bslot_nxt = '0;
                slot_nxt  = (slot == SLOT_W'(MAX_SLOTS)) ? slot : slot + SLOT_W'(1);
            end else begin
                bslot_nxt = bslot + BIT_W'(1);
                slot_nxt  = slot;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pos   <= '0;
            slot  <= '0;
            bslot <= '0;
        end else if (step) begin
            pos   <= pos_nxt;
            slot  <= slot_nxt;
            bslot <= bslot_nxt;
        end
    end
endmodule

// File: rtl/tdm_fs_shaper.sv
module tdm_fs_shaper #(
    parameter int FRAME_W = 8,
    parameter int FSLEN_W = 7
) (
    input  logic [FRAME_W-1:0] pos,
    input  logic [FRAME_W-1:0] last_pos,
    input  logic [FSLEN_W-1:0] fs_len_m1,
    input  logic               early,
    input  logic               active_high,
    output logic               fs_level
);
    logic [FRAME_W-1:0] phase;
    logic               in_window;

    always_comb begin
        if (early) begin
            phase = (pos >= last_pos) ? '0 : pos + FRAME_W'(1);
        end else begin
            phase = pos;
        end
        in_window = (phase <= FRAME_W'(fs_len_m1));
        fs_level  = active_high ? in_window : !in_window;
    end
endmodule

// File: rtl/tdm_bit_picker.sv
module tdm_bit_picker #(
    parameter int WORD_W = 32,
    parameter int BIT_W  = 6
) (
    input  logic [WORD_W-1:0] word,
    input  logic [BIT_W-1:0]  bslot,
    input  logic [BIT_W-1:0]  first_off,
    input  logic [BIT_W-1:0]  data_m1,
    input  logic              lsb_first,
    output logic              bit_out
);
    localparam int IDX_W = $clog2(WORD_W);

    logic [BIT_W:0]   k;
    logic             in_win;
    logic [IDX_W-1:0] idx;

    always_comb begin
        k      = {1'b0, bslot} - {1'b0, first_off};
        in_win = (bslot >= first_off) && (k <= {1'b0, data_m1});
        idx    = lsb_first ? IDX_W'(k) : IDX_W'(data_m1 - k[BIT_W-1:0]);
        bit_out = in_win && word[idx];
    end
endmodule

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx
    import tdm_tx_pkg::*;
#(
    parameter int FRAME_W   = 8,
    parameter int FSLEN_W   = 7,
    parameter int MAX_SLOTS = 16,
    parameter int WORD_W    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bclk_en,
    input  logic                         cfg_enable,
    input  logic [FRAME_W-1:0]           cfg_frame_len_m1,
    input  logic [FSLEN_W-1:0]           cfg_fs_len_m1,
    input  logic                         cfg_fs_active_high,
    input  logic                         cfg_fs_early,
    input  logic [$clog2(MAX_SLOTS)-1:0] cfg_slot_count_m1,
    input  logic [MAX_SLOTS-1:0]         cfg_slot_mask,
    input  logic [1:0]                   cfg_slot_size,
    input  logic [$clog2(WORD_W)-1:0]    cfg_data_bits_m1,
    input  logic [$clog2(WORD_W)-1:0]    cfg_first_bit_off,
    input  logic                         cfg_lsb_first,
    input  logic                         cfg_idle_hiz,
    input  logic                         cfg_mute_req,
    input  logic                         cfg_mute_repeat,
    input  logic [WORD_W-1:0]            in_data,
    input  logic                         in_valid,
    output logic                         in_ready,
    output logic                         fs,
    output logic                         sd,
    output logic                         sd_oe,
    output logic                         underrun
);
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int BIT_W  = IDX_W + 1;
    localparam int CNT_W  = $clog2(MAX_SLOTS);
    localparam int SLOT_W = CNT_W + 1;

    tx_state_e         state_q, state_d;
    logic [FRAME_W-1:0] pos;
    logic [SLOT_W-1:0]  slot, slot_nxt;
    logic [BIT_W-1:0]   bslot, slot_bits;
    logic               frame_end, running, emit, fetch, in_slot, running_chk;
    logic               fs_level, pick_bit;
    logic [WORD_W-1:0]  held_word, last_word, fetched, word_now, tx_word;
    logic               muted_q;

    function automatic logic slot_on(input logic [SLOT_W-1:0] s);
        return (s <= {1'b0, cfg_slot_count_m1}) && cfg_slot_mask[s[CNT_W-1:0]];
    endfunction

    always_comb begin
        unique case (slot_size_e'(cfg_slot_size))
            SZ_DATA: slot_bits = {1'b0, cfg_data_bits_m1} + BIT_W'(1);
            SZ_16:   slot_bits = BIT_W'(16);
            default: slot_bits = BIT_W'(WORD_W);
        endcase
    end

    assign running     = (state_q != ST_IDLE);
    assign running_chk = running;
    assign in_slot     = (state_q == ST_SLOT);
    assign emit        = running && cfg_enable && bclk_en;
    assign fetch       = emit && in_slot && (bslot == '0);
    assign in_ready    = fetch;

    tdm_pos_counter #(
        .FRAME_W(FRAME_W), .SLOT_W(SLOT_W), .BIT_W(BIT_W), .MAX_SLOTS(MAX_SLOTS)
    ) pos_cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!running || !cfg_enable),
        .step     (emit),
        .last_pos (cfg_frame_len_m1),
        .slot_bits(slot_bits),
        .pos      (pos),
        .slot     (slot),
        .bslot    (bslot),
        .slot_nxt (slot_nxt),
        .frame_end(frame_end)
    );

    tdm_fs_shaper #(.FRAME_W(FRAME_W), .FSLEN_W(FSLEN_W)) fs_shape_i (
        .pos        (pos),
        .last_pos   (cfg_frame_len_m1),
        .fs_len_m1  (cfg_fs_len_m1),
        .early      (cfg_fs_early),
        .active_high(cfg_fs_active_high),
        .fs_level   (fs_level)
    );

    always_comb begin
        fetched  = in_valid ? in_data : '0;
        word_now = (bslot == '0) ? fetched : held_word;
        if (muted_q) begin
            tx_word = cfg_mute_repeat ? last_word : '0;
        end else begin
            tx_word = word_now;
        end
    end

    tdm_bit_picker #(.WORD_W(WORD_W), .BIT_W(BIT_W)) picker_i (
        .word     (tx_word),
        .bslot    (bslot),
        .first_off({1'b0, cfg_first_bit_off}),
        .data_m1  ({1'b0, cfg_data_bits_m1}),
        .lsb_first(cfg_lsb_first),
        .bit_out  (pick_bit)
    );

    // Next-state logic: the state names the class of the counter position.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_enable) state_d = slot_on('0) ? ST_SLOT : ST_QUIET;
            end
            ST_SLOT, ST_QUIET: begin
                if (!cfg_enable) begin
                    state_d = ST_IDLE;
                end else if (emit) begin
                    state_d = slot_on(slot_nxt) ? ST_SLOT : ST_QUIET;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs    <= 1'b0;
            sd    <= 1'b0;
            sd_oe <= 1'b0;
        end else if (!running || !cfg_enable) begin
            fs    <= !cfg_fs_active_high;
            sd    <= 1'b0;
            sd_oe <= 1'b0;
        end else if (emit) begin
            fs <= fs_level;
            if (in_slot) begin
                sd    <= pick_bit;
                sd_oe <= 1'b1;
            end else begin
                sd    <= 1'b0;
                sd_oe <= !cfg_idle_hiz;
            end
        end
    end

    // Word holding, mute sampling and underrun flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_word <= '0;
            last_word <= '0;
            muted_q   <= 1'b0;
            underrun  <= 1'b0;
        end else begin
            if (fetch) begin
                held_word <= fetched;
                if (!muted_q) last_word <= fetched;
                if (!in_valid) underrun <= 1'b1;
            end
            if ((state_q == ST_IDLE && cfg_enable) || (emit && frame_end)) begin
                muted_q <= cfg_mute_req;
            end
        end
    end
endmodule

// File: rtl/tdm_frame_tx_chk.sv
module tdm_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bclk_en,
    input logic cfg_enable,
    input logic in_ready,
    input logic in_slot,
    input logic running,
    input logic fs,
    input logic sd,
    input logic sd_oe,
    input logic underrun
);
    p_ready_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (bclk_en && cfg_enable && in_slot));

    p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cfg_enable && !bclk_en) |=> ($stable(fs) && $stable(sd) && $stable(sd_oe)));

    p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (!sd_oe && !sd));

    p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

    p_slot_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> sd_oe);
endmodule

bind tdm_frame_tx tdm_frame_tx_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_en   (bclk_en),
    .cfg_enable(cfg_enable),
    .in_ready  (in_ready),
    .in_slot   (in_slot),
    .running   (running_chk),
    .fs        (fs),
    .sd        (sd),
    .sd_oe     (sd_oe),
    .underrun  (underrun)
);

// File: tb/tdm_frame_tx_tb_top.sv
module tdm_frame_tx_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_en = 1'b0;
    logic        enable = 1'b0;
    logic [7:0]  flen_m1 = 8'd63;
    logic [6:0]  fslen_m1 = 7'd0;
    logic        pol = 1'b1, early = 1'b0;
    logic [3:0]  cnt_m1 = 4'd0;
    logic [15:0] mask = 16'h0;
    logic [1:0]  ssize = 2'd2;
    logic [4:0]  dbm1 = 5'd31, off = 5'd0;
    logic        lsb = 1'b0, hiz = 1'b0, mute_req = 1'b0, rep = 1'b0;
    logic [31:0] in_data = 32'h0;
    logic        in_valid = 1'b0;
    logic        in_ready, fs, sd, sd_oe, underrun;

    int          n_checks = 0, n_errors = 0;
    int          p = 0;
    bit          m_muted = 0, m_under = 0;
    logic [31:0] m_cur = 0, m_last = 0;
    int unsigned word_seed = 1;
    logic [31:0] fifo_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_frame_tx dut_i (
        .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .cfg_enable(enable),
        .cfg_frame_len_m1(flen_m1), .cfg_fs_len_m1(fslen_m1),
        .cfg_fs_active_high(pol), .cfg_fs_early(early),
        .cfg_slot_count_m1(cnt_m1), .cfg_slot_mask(mask), .cfg_slot_size(ssize),
        .cfg_data_bits_m1(dbm1), .cfg_first_bit_off(off), .cfg_lsb_first(lsb),
        .cfg_idle_hiz(hiz), .cfg_mute_req(mute_req), .cfg_mute_repeat(rep),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .fs(fs), .sd(sd), .sd_oe(sd_oe), .underrun(underrun)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s pos=%0d actual=%0h expected=%0h", what, p, act, exp);
        end
    endtask

    function automatic int slot_w();
        case (ssize)
            2'd0:    return int'(dbm1) + 1;
            2'd1:    return 16;
            default: return 32;
        endcase
    endfunction

    function automatic bit slot_act(input int s);
        if (s <= int'(cnt_m1)) return mask[s];
        return 1'b0;
    endfunction

    function automatic int fetches_per_frame();
        int n = 0;
        for (int q = 0; q <= int'(flen_m1); q++) begin
            if (slot_act(q / slot_w()) && (q % slot_w()) == 0) n++;
        end
        return n;
    endfunction

    task automatic feed(input int n);
        for (int i = 0; i < n; i++) begin
            word_seed = word_seed * 32'd1664525 + 32'd1013904223;
            fifo_q.push_back(word_seed ^ (word_seed >> 13));
        end
    endtask

    task automatic set_cfg(input int fl, input int fsl, input bit e, input bit pl,
                           input int c, input int mk, input int sz, input int db,
                           input int of, input bit lb, input bit hz);
        flen_m1 = 8'(fl); fslen_m1 = 7'(fsl); early = e; pol = pl;
        cnt_m1 = 4'(c); mask = 16'(mk); ssize = 2'(sz); dbm1 = 5'(db);
        off = 5'(of); lsb = lb; hiz = hz;
    endtask

    task automatic start_run();
        @(negedge clk);
        enable = 1'b1;
        p = 0;
        m_muted = mute_req;
        m_cur = 0;
        @(negedge clk);
    endtask

    task automatic stop_run();
        @(negedge clk);
        enable = 1'b0;
        fifo_q.delete();
        @(negedge clk);
        chk("R1 R11 oe after stop", 32'(sd_oe), 32'd0);
        chk("R1 R11 sd after stop", 32'(sd), 32'd0);
        chk("R1 R11 fs after stop", 32'(fs), 32'(!pol));
        chk("R1 ready after stop", 32'(in_ready), 32'd0);
    endtask

    task automatic tick(input string tag);
        int L, sb, s, b, k, q;
        bit act, exp_rdy, exp_sd, exp_oe, exp_fs, nxt_mute;
        logic [31:0] tx;
        L  = int'(flen_m1) + 1;
        sb = slot_w();
        s  = p / sb;
        b  = p % sb;
        act = slot_act(s);
        exp_rdy = act && (b == 0);
        nxt_mute = m_muted;
        if (p == L - 1) nxt_mute = mute_req;
        bclk_en  = 1'b1;
        in_valid = (fifo_q.size() > 0);
        in_data  = in_valid ? fifo_q[0] : 32'hDEAD_BEEF;
        #1;
        chk("R7 ready", 32'(in_ready), 32'(exp_rdy));
        if (exp_rdy) begin
            if (fifo_q.size() > 0) m_cur = fifo_q.pop_front();
            else begin m_cur = 32'h0; m_under = 1'b1; end
            if (!m_muted) m_last = m_cur;
        end
        tx = m_muted ? (rep ? m_last : 32'h0) : m_cur;
        if (act) begin
            k = b - int'(off);
            if (b >= int'(off) && k <= int'(dbm1))
                exp_sd = tx[lsb ? k : int'(dbm1) - k];
            else
                exp_sd = 1'b0;
            exp_oe = 1'b1;
        end else begin
            exp_sd = 1'b0;
            exp_oe = !hiz;
        end
        q = (p + int'(early)) % L;
        exp_fs = pol ? (q <= int'(fslen_m1)) : !(q <= int'(fslen_m1));
        @(negedge clk);
        bclk_en  = 1'b0;
        in_valid = 1'b0;
        chk("R3 fs", 32'(fs), 32'(exp_fs));
        chk(act ? {tag, " sd"} : "R6 sd idle", 32'(sd), 32'(exp_sd));
        chk(act ? {tag, " oe"} : "R6 oe idle", 32'(sd_oe), 32'(exp_oe));
        chk("R8 underrun flag", 32'(underrun), 32'(m_under));
        @(negedge clk);
        chk("R2 hold sd", 32'(sd), 32'(exp_sd));
        chk("R2 hold fs", 32'(fs), 32'(exp_fs));
        m_muted = nxt_mute;
        p = (p + 1) % L;
    endtask

    task automatic run_frames(input int frames, input string tag);
        feed(fetches_per_frame() * frames);
        start_run();
        for (int t = 0; t < frames * (int'(flen_m1) + 1); t++) tick(tag);
        stop_run();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state with enable low
        chk("R1 oe reset", 32'(sd_oe), 32'd0);
        chk("R1 sd reset", 32'(sd), 32'd0);
        chk("R1 fs reset", 32'(fs), 32'(!pol));
        chk("R1 ready reset", 32'(in_ready), 32'd0);
        chk("R8 underrun reset", 32'(underrun), 32'd0);

        // I2S: 64-bit frame, 32-bit sync, early, active low, two 32-bit slots of 20-bit data
        set_cfg(63, 31, 1, 0, 1, 3, 2, 19, 0, 0, 0);
        run_frames(2, "R5 i2s");

        // Sweep R4/R5/R6/R3 over a 40-bit frame with two 16-bit slots and a tail
        for (int mk = 0; mk < 4; mk++)
            for (int lb = 0; lb < 2; lb++)
                for (int hz = 0; hz < 2; hz++)
                    for (int e = 0; e < 2; e++) begin
                        set_cfg(39, 3, e[0], hz[0] ^ lb[0], 1, mk, 1, 11, 2, lb[0], hz[0]);
                        run_frames(2, "R4 R5 sweep");
                    end

        // Slot width equal to data width (R4 code 0), tail, masked middle slot
        set_cfg(39, 0, 0, 1, 2, 5, 0, 11, 0, 0, 1);
        run_frames(2, "R4 datasize");

        // Data offset inside a 32-bit slot with 8-bit data
        set_cfg(47, 7, 0, 1, 0, 1, 2, 7, 4, 0, 0);
        run_frames(2, "R5 offset");

        // TDM: eight 16-bit slots, sparse mask, one-bit sync
        set_cfg(127, 0, 0, 1, 7, 16'h00A5, 1, 15, 0, 1, 1);
        run_frames(1, "R4 tdm");

        // Largest frame: 256 bits, sixteen 16-bit slots, 128-bit sync
        set_cfg(255, 127, 0, 0, 15, 16'hFFFF, 1, 13, 1, 0, 0);
        run_frames(1, "R4 R3 max");

        // Mute requested mid-frame: R9 takes effect next frame, R10 content
        for (int r = 0; r < 2; r++) begin
            set_cfg(63, 31, 1, 0, 1, 3, 2, 19, 0, 0, 0);
            rep = r[0];
            mute_req = 1'b0;
            feed(fetches_per_frame() * 3);
            start_run();
            for (int t = 0; t < 192; t++) begin
                if (t == 10) mute_req = 1'b1;
                if (t == 74) mute_req = 1'b0;
                tick("R9 R10 mute");
            end
            stop_run();
        end
        rep = 1'b0;

        // Mute requested before start: first frame already muted (R9)
        mute_req = 1'b1;
        set_cfg(63, 0, 0, 1, 3, 16'h000F, 1, 15, 0, 0, 0);
        feed(fetches_per_frame());
        start_run();
        mute_req = 1'b0;
        for (int t = 0; t < 128; t++) tick("R9 R10 start mute");
        stop_run();

        // Underrun: only one word for two active slots (R8)
        set_cfg(63, 0, 0, 1, 3, 16'h0009, 1, 15, 0, 0, 1);
        feed(1);
        start_run();
        for (int t = 0; t < 64; t++) tick("R8 underrun");
        stop_run();
        chk("R8 underrun sticky", 32'(underrun), 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule